// File: doc/BRIEF.md
# Railway Route Interlocking Controller

This block keeps one lock bit for each of five railway routes and updates all of them once per clock cycle. A cycle runs four phases in a fixed order. First it grants routes that are commanded and safe to lock. Then it frees routes that a train has finished with. Then it sets the point switches to match the locks. Last it sets the route signals to match the locks. All four phases work in combinational logic within one cycle, and one register stage holds the lock vector, the switch positions and the signal aspects. The three outputs change together at the same clock edge, so they always agree.

Commands arrive from several command stations, each with one request bit per route, and the block merges them with a bitwise OR. A route is granted only when three things hold: it is requested, no route that shares track with it is locked, and every track segment it uses is reported clear. When several requests contend, routes are checked from route 0 upward against the locks granted so far, so the lower index wins. A refused request is not dropped. It stays pending for as long as a station keeps asserting it, and it is granted once nothing blocks it. The track layout is fixed when the design is built: which segments each route uses, and which point switches it needs in which position. Two routes conflict when they share a segment.

Top module: `route_interlock`

## Requirements
- R1: While `rst` is high, the next clock edge clears all lock bits, sets every signal to stop (0) and sets every switch to normal (0).
- R2: The request for route r is the OR of `tc_i[s*5 + r]` over all stations s. A requested route that is unlocked, free of conflicts and clear of occupancy shows in `lock_o` after the next clock edge.
- R3: A route that no station requests is never newly locked.
- R4: A request for a route that conflicts with an already locked route is refused. The request stays pending and is granted at the edge after the conflicting lock is released. Conflicts follow from shared segments, which gives the pairs 0-1, 1-4, 2-3 and 3-4.
- R5: A route is not locked while any of its segments reads occupied in `occ_i`. The segments are: route 0 uses {0,1}, route 1 uses {0,2}, route 2 uses {3,4}, route 3 uses {3,5} and route 4 uses {2,5}.
- R6: When conflicting routes are requested in the same cycle, only the lowest-numbered one is granted. A later route is still granted if it conflicts with none of the routes granted before it in that order.
- R7: A set `passed_i[r]` clears lock bit r at the next edge. Release comes after locking, so a route that is requested and marked passed in the same cycle ends unlocked. A passed mark on an unlocked route has no effect.
- R8: Switch positions (1 = reverse) follow the locked routes. Route 0 needs switch 0 normal, route 1 needs switch 0 reverse, route 2 needs switch 1 normal, route 3 needs switch 1 and switch 2 reverse, and route 4 needs switch 2 normal. A switch that no locked route uses keeps its last position.
- R9: `signal_o[r]` shows proceed (1) exactly when route r is locked. It returns to stop at the same edge at which the route is released.
- R10: Two conflicting routes are never locked at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one interlocking cycle per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tc_i | input | N_STATIONS*5 | Route requests, 5 bits per station, station s at bits s*5+4..s*5 |
| occ_i | input | 6 | Track segment occupied flags (1 = occupied) |
| passed_i | input | 5 | Per-route train-has-passed indications |
| lock_o | output | 5 | Route lock vector (1 = locked) |
| switch_o | output | 3 | Point switch commands (0 = normal, 1 = reverse) |
| signal_o | output | 5 | Route signal aspects (0 = stop, 1 = proceed) |

## Verification
The assertions check on every cycle that no conflicting pair is locked and that each signal equals its lock bit. They also check that every locked route has its switches in the required position, and that every newly granted lock had a request and clear segments in the cycle before. They cannot show that a refused request is later granted, which route wins a contention, that release takes priority over a grant in the same cycle, or that an unused switch holds its position. Directed scenarios in the bench show those with exact expected vectors.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    localparam int NUM_ROUTES   = 5;
    localparam int NUM_SEGS     = 6;
    localparam int NUM_SWITCHES = 3;

    typedef logic [NUM_ROUTES-1:0]   route_vec_t;
    typedef logic [NUM_SEGS-1:0]     seg_vec_t;
    typedef logic [NUM_SWITCHES-1:0] sw_vec_t;

    typedef enum logic {
        ASPECT_STOP    = 1'b0,
        ASPECT_PROCEED = 1'b1
    } aspect_e;

    typedef enum logic {
        POS_NORMAL  = 1'b0,
        POS_REVERSE = 1'b1
    } sw_pos_e;

    typedef struct packed {
        route_vec_t lock;
        sw_vec_t    sw;
        route_vec_t sig;
    } ilk_state_t;

    // Track segments used by each route.
    function automatic seg_vec_t route_segs(input int r);
        seg_vec_t m;
        m = '0;
        case (r)
            0: m = 6'b000011;
            1: m = 6'b000101;
            2: m = 6'b011000;
            3: m = 6'b101000;
            4: m = 6'b100100;
            default: m = '0;
        endcase
        return m;
    endfunction

    // Switches that a route sets.
    function automatic sw_vec_t route_sw_used(input int r);
        sw_vec_t m;
        m = '0;
        case (r)
            0: m = 3'b001;
            1: m = 3'b001;
            2: m = 3'b010;
            3: m = 3'b110;
            4: m = 3'b100;
            default: m = '0;
        endcase
        return m;
    endfunction

    // Required positions of the switches a route sets (1 = reverse).
    function automatic sw_vec_t route_sw_pos(input int r);
        sw_vec_t m;
        m = '0;
        case (r)
            1: m = 3'b001;
            3: m = 3'b110;
            default: m = '0;
        endcase
        return m;
    endfunction

    // Routes that share at least one segment with route r.
    function automatic route_vec_t conflict_row(input int r);
        route_vec_t m;
        m = '0;
        for (int b = 0; b < NUM_ROUTES; b++) begin
            if (b != r && (route_segs(r) & route_segs(b)) != '0)
                m[b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/ilk_req_merge.sv
module ilk_req_merge
    import ilk_pkg::*;
#(
    parameter int N_STATIONS = 3
) (
    input  logic [N_STATIONS*NUM_ROUTES-1:0] tc_i,
    output route_vec_t                       req_o
);
    localparam int LAST = N_STATIONS - 1;

    route_vec_t partial [N_STATIONS];

    assign partial[0] = tc_i[NUM_ROUTES-1:0];

    genvar s;
    generate
        for (s = 1; s < N_STATIONS; s++) begin : g_stn
            assign partial[s] = partial[s-1] | tc_i[s*NUM_ROUTES +: NUM_ROUTES];
        end
    endgenerate

    assign req_o = partial[LAST];
endmodule

// File: rtl/ilk_lock_phase.sv
module ilk_lock_phase
    import ilk_pkg::*;
(
    input  route_vec_t lock_q,
    input  route_vec_t req,
    input  seg_vec_t   occ,
    input  route_vec_t passed,
    output route_vec_t lock_next
);
    route_vec_t granted;

    // Phase 1: walk the routes in index order against the locks so far.
    always_comb begin
        granted = lock_q;
        for (int r = 0; r < NUM_ROUTES; r++) begin
            if (req[r] && !granted[r]
                && (granted & conflict_row(r)) == '0
                && (occ & route_segs(r)) == '0)
                granted[r] = 1'b1;
        end
    end

    // Phase 2: release routes the train has left.
    assign lock_next = granted & ~passed;
endmodule

// File: rtl/ilk_switch_phase.sv
module ilk_switch_phase
    import ilk_pkg::*;
(
    input  route_vec_t lock_next,
    input  sw_vec_t    sw_q,
    output sw_vec_t    sw_next
);
    genvar w;
    generate
        for (w = 0; w < NUM_SWITCHES; w++) begin : g_sw
            logic    claimed;
            sw_pos_e want;
            always_comb begin
                claimed = 1'b0;
                want    = POS_NORMAL;
                for (int r = 0; r < NUM_ROUTES; r++) begin
                    if (lock_next[r] && route_sw_used(r)[w]) begin
                        claimed = 1'b1;
                        want    = sw_pos_e'(route_sw_pos(r)[w]);
                    end
                end
            end
            assign sw_next[w] = claimed ? want : sw_q[w];
        end
    endgenerate
endmodule

// File: rtl/ilk_signal_phase.sv
module ilk_signal_phase
    import ilk_pkg::*;
(
    input  route_vec_t lock_next,
    output route_vec_t sig_next
);
    genvar r;
    generate
        for (r = 0; r < NUM_ROUTES; r++) begin : g_sig
            aspect_e asp;
            assign asp         = lock_next[r] ? ASPECT_PROCEED : ASPECT_STOP;
            assign sig_next[r] = asp;
        end
    endgenerate
endmodule

// File: rtl/route_interlock.sv
module route_interlock
    import ilk_pkg::*;
#(
    parameter int N_STATIONS = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [N_STATIONS*NUM_ROUTES-1:0] tc_i,
    input  logic [NUM_SEGS-1:0]              occ_i,
    input  logic [NUM_ROUTES-1:0]            passed_i,
    output logic [NUM_ROUTES-1:0]            lock_o,
    output logic [NUM_SWITCHES-1:0]          switch_o,
    output logic [NUM_ROUTES-1:0]            signal_o
);
    ilk_state_t st_q;
    ilk_state_t st_d;
    route_vec_t req;

    ilk_req_merge #(.N_STATIONS(N_STATIONS)) u_merge (
        .tc_i  (tc_i),
        .req_o (req)
    );

    ilk_lock_phase u_lock (
        .lock_q    (st_q.lock),
        .req       (req),
        .occ       (occ_i),
        .passed    (passed_i),
        .lock_next (st_d.lock)
    );

    ilk_switch_phase u_sw (
        .lock_next (st_d.lock),
        .sw_q      (st_q.sw),
        .sw_next   (st_d.sw)
    );

    ilk_signal_phase u_sig (
        .lock_next (st_d.lock),
        .sig_next  (st_d.sig)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.lock <= '0;
            st_q.sw   <= {NUM_SWITCHES{POS_NORMAL}};
            st_q.sig  <= {NUM_ROUTES{ASPECT_STOP}};
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_o   = st_q.lock;
    assign switch_o = st_q.sw;
    assign signal_o = st_q.sig;
endmodule

// File: rtl/ilk_checker.sv
module ilk_checker
    import ilk_pkg::*;
#(
    parameter int N_STATIONS = 3
) (
    input logic                             clk,
    input logic                             rst,
    input logic [N_STATIONS*NUM_ROUTES-1:0] tc_i,
    input logic [NUM_SEGS-1:0]              occ_i,
    input logic [NUM_ROUTES-1:0]            lock_o,
    input logic [NUM_SWITCHES-1:0]          switch_o,
    input logic [NUM_ROUTES-1:0]            signal_o
);
    route_vec_t any_req;
    route_vec_t seg_clear;
    logic       clash;

    always_comb begin
        any_req   = '0;
        seg_clear = '0;
        clash     = 1'b0;
        for (int s = 0; s < N_STATIONS; s++)
            any_req = any_req | tc_i[s*NUM_ROUTES +: NUM_ROUTES];
        for (int r = 0; r < NUM_ROUTES; r++) begin
            seg_clear[r] = (occ_i & route_segs(r)) == '0;
            for (int b = r + 1; b < NUM_ROUTES; b++)
                if (lock_o[r] && lock_o[b] && (route_segs(r) & route_segs(b)) != '0)
                    clash = 1'b1;
        end
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (lock_o == '0 && signal_o == '0 && switch_o == '0));

    p_grant_needs_req_r3: assert property (@(posedge clk) disable iff (rst)
        ((lock_o & ~$past(lock_o) & ~$past(any_req)) == '0));

    p_grant_needs_clear_r5: assert property (@(posedge clk) disable iff (rst)
        ((lock_o & ~$past(lock_o) & ~$past(seg_clear)) == '0));

    p_signal_tracks_lock_r9: assert property (@(posedge clk) disable iff (rst)
        signal_o == lock_o);

    p_no_conflict_r10: assert property (@(posedge clk) disable iff (rst)
        !clash);

    genvar r;
    generate
        for (r = 0; r < NUM_ROUTES; r++) begin : g_route
            localparam sw_vec_t USED = route_sw_used(r);
            localparam sw_vec_t POS  = route_sw_pos(r);
            p_switch_set_r8: assert property (@(posedge clk) disable iff (rst)
                lock_o[r] |-> ((switch_o & USED) == (POS & USED)));
        end
    endgenerate
endmodule

bind route_interlock ilk_checker #(.N_STATIONS(N_STATIONS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tc_i     (tc_i),
    .occ_i    (occ_i),
    .lock_o   (lock_o),
    .switch_o (switch_o),
    .signal_o (signal_o)
);

// File: tb/sim_route_interlock.sv
module sim_route_interlock;
    localparam int CLK_PERIOD = 10;
    localparam int NST = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic [14:0] tc_i;
    logic [5:0]  occ_i;
    logic [4:0]  passed_i;
    logic [4:0]  lock_o;
    logic [2:0]  switch_o;
    logic [4:0]  signal_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    route_interlock #(.N_STATIONS(NST)) u0 (
        .clk(clk), .rst(rst), .tc_i(tc_i), .occ_i(occ_i),
        .passed_i(passed_i), .lock_o(lock_o), .switch_o(switch_o),
        .signal_o(signal_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    function automatic logic [14:0] stn(input int s, input logic [4:0] m);
        logic [14:0] v;
        v = '0;
        v[s*5 +: 5] = m;
        return v;
    endfunction

    task automatic expect_state(input string req, input logic [4:0] lk, input logic [2:0] sw);
        checks++;
        if (lock_o !== lk || signal_o !== lk || switch_o !== sw) begin
            failures++;
            $display("FAIL %s: lock=%b sig=%b sw=%b expected lock=%b sig=%b sw=%b",
                     req, lock_o, signal_o, switch_o, lk, lk, sw);
        end
    endtask

    task automatic release_all();
        tc_i = '0; occ_i = '0; passed_i = 5'h1F;
        tick();
        passed_i = '0;
    endtask

    task automatic t_reset();
        rst = 1'b1; tc_i = '0; occ_i = '0; passed_i = '0;
        tick(); tick();
        expect_state("R1 reset", 5'b00000, 3'b000);
        rst = 1'b0;
        tick();
        expect_state("R3 idle no request", 5'b00000, 3'b000);
    endtask

    task automatic t_basic_grant();
        tc_i = stn(1, 5'b00001);
        tick();
        expect_state("R2 grant route0 station1", 5'b00001, 3'b000);
        tick();
        expect_state("R2 lock held", 5'b00001, 3'b000);
        tc_i = '0; passed_i = 5'b00001;
        tick();
        passed_i = '0;
        expect_state("R9 release to stop", 5'b00000, 3'b000);
    endtask

    task automatic t_or_and_switch();
        tc_i = stn(2, 5'b00010);
        tick();
        expect_state("R2 R8 route1 station2 sw0 reverse", 5'b00010, 3'b001);
        tc_i = '0; passed_i = 5'b00010;
        tick();
        passed_i = '0;
        expect_state("R8 switch holds after release", 5'b00000, 3'b001);
    endtask

    task automatic t_conflict_pending();
        tc_i = stn(0, 5'b00010);
        tick();
        expect_state("R4 route1 locked", 5'b00010, 3'b001);
        tc_i = stn(0, 5'b00011);
        tick();
        expect_state("R4 route0 refused", 5'b00010, 3'b001);
        tc_i = stn(0, 5'b00001); passed_i = 5'b00010;
        tick();
        passed_i = '0;
        expect_state("R4 release edge, route0 still pending", 5'b00000, 3'b001);
        tick();
        expect_state("R4 pending route0 granted", 5'b00001, 3'b000);
        release_all();
    endtask

    task automatic t_occupied();
        tc_i = stn(0, 5'b00100); occ_i = 6'b010000;
        tick();
        expect_state("R5 seg4 occupied blocks route2", 5'b00000, 3'b000);
        occ_i = 6'b000000;
        tick();
        expect_state("R5 cleared segment grants route2", 5'b00100, 3'b000);
        occ_i = 6'b111111;
        tick();
        expect_state("R5 occupancy does not drop locked route", 5'b00100, 3'b000);
        release_all();
    endtask

    task automatic t_contention();
        tc_i = stn(0, 5'b01000) | stn(1, 5'b00100) | stn(2, 5'b10000);
        tick();
        expect_state("R6 R10 route2 beats route3, route4 granted", 5'b10100, 3'b000);
        release_all();
        tc_i = stn(1, 5'b01000);
        tick();
        expect_state("R8 route3 sw1 sw2 reverse", 5'b01000, 3'b110);
        release_all();
        tick();
        expect_state("R8 switches hold when unused", 5'b00000, 3'b110);
    endtask

    task automatic t_same_cycle_release();
        tc_i = stn(0, 5'b00001); passed_i = 5'b00001;
        tick();
        expect_state("R7 release wins over grant", 5'b00000, 3'b110);
        tc_i = '0; passed_i = 5'b11111;
        tick();
        passed_i = '0;
        expect_state("R7 passed on unlocked no effect", 5'b00000, 3'b110);
    endtask

    task automatic t_reset_mid();
        tc_i = stn(2, 5'b00010);
        tick();
        expect_state("R2 route1 before reset", 5'b00010, 3'b111);
        rst = 1'b1;
        tick();
        rst = 1'b0; tc_i = '0;
        expect_state("R1 reset clears locked state", 5'b00000, 3'b000);
    endtask

    initial begin
        t_reset();
        t_basic_grant();
        t_or_and_switch();
        t_conflict_pending();
        t_occupied();
        t_contention();
        t_same_cycle_release();
        t_reset_mid();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule